// File: doc/BRIEF.md
# Exception Vector Base Address Unit

This block keeps the base address of the exception vector table and turns an exception vector number into the memory address of that vector's entry. Only the top twelve bits of the 32-bit base are kept. The twenty low bits are always zero when an address is formed, so the table always starts on a 1-Mbyte boundary.

The entry address is the base plus four times the 8-bit vector number. Each entry is four bytes, so the largest displacement is 0x3FC. The address is combinational, so it follows the vector number and the stored base in the same cycle.

Software can write the base in two ways: from the processor's move-to-control-register operation, or from a debug serial command. Both use the same 12-bit control register code. Only the debug side can read the base back. A read request from the processor side has no effect.

Top module: `vec_base_unit`

## Requirements
- R1: After synchronous active-low reset the stored base is zero. The vector address then equals vector number × 4, and `dbg_rd_valid` is 0.
- R2: A processor-side write with `cpu_wr_en`=1 and `cpu_wr_code`=0x801 stores `cpu_wr_data[31:20]`. The new base is visible from the next cycle. `cpu_wr_data[19:0]` has no effect.
- R3: A debug-side write with `dbg_wr_en`=1 and `dbg_wr_code`=0x801 stores `dbg_wr_data[31:20]`. The new base is visible from the next cycle. The low 20 data bits have no effect.
- R4: A write whose code is not 0x801 leaves the stored base unchanged. The same holds in any cycle with no write.
- R5: If both sources write with code 0x801 in the same cycle, the debug data is stored and the processor data is dropped.
- R6: `vec_addr` = {base[31:20], 20'h0} + (`vec_num` × 4) in the same cycle, with no carry into bits 31:20. The maximum vector 0xFF gives base | 0x3FC.
- R7: A debug read with `dbg_rd_en`=1 and `dbg_rd_code`=0x801 raises `dbg_rd_valid` for exactly one cycle, on the cycle after the request. `dbg_rd_data` then carries the base as it stood on the request cycle in bits 31:20, with bits 19:0 driven zero. A write in the same cycle as the read is not reflected.
- R8: A debug read with any other code leaves `dbg_rd_valid` at 0 on the following cycle.
- R9: A processor-side read (`cpu_rd_en`, any `cpu_rd_code`) produces no read response and does not change the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr_en | input | 1 | Processor control-register write strobe |
| cpu_wr_code | input | 12 | Processor control register code |
| cpu_wr_data | input | 32 | Processor write data |
| cpu_rd_en | input | 1 | Processor read attempt (ignored) |
| cpu_rd_code | input | 12 | Code of processor read attempt (ignored) |
| dbg_wr_en | input | 1 | Debug write strobe |
| dbg_wr_code | input | 12 | Debug control register code for writes |
| dbg_wr_data | input | 32 | Debug write data |
| dbg_rd_en | input | 1 | Debug read strobe |
| dbg_rd_code | input | 12 | Debug control register code for reads |
| dbg_rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| dbg_rd_data | output | 32 | Base in bits 31:20, zeros below |
| vec_num | input | 8 | Exception vector number |
| vec_addr | output | 32 | Address of the vector entry |

## Verification
Directed cases cover the following:
- the reset state;
- the largest vector (0xFF) under an all-ones base, which would expose a carry into the base bits or a missing shift;
- writes with nonzero low data bits, which show whether those bits leak into the base;
- codes one bit away from 0x801, which test the decoder;
- simultaneous writes from both sources, which settle the priority;
- a read issued in the same cycle as a write, which separates sampling the old base from sampling the new one.

Random cycles then mix writes from each source, wrong codes, processor read attempts and debug reads with random vector numbers. Every cycle compares the address and any read response with a bench model of the base.

// File: rtl/vbu_pkg.sv
// Package: shared constants for the vector base address unit.
// Assumes a 32-bit address space with 4-byte vector table entries.
package vbu_pkg;
    localparam int unsigned ADDR_W      = 32;
    localparam int unsigned BASE_W      = 12;
    localparam int unsigned CODE_W      = 12;
    localparam int unsigned VEC_W       = 8;
    localparam int unsigned ENTRY_SHIFT = 2;
    localparam logic [CODE_W-1:0] VBASE_CODE = 12'h801;
endpackage

// File: rtl/vbu_wr_select.sv
// Module: picks the write that updates the base register.
// It accepts a processor-side and a debug-side write, each qualified by the
// control register code. Debug has priority when both hit in one cycle.
// Assumes the low data bits below the stored field carry no meaning.
module vbu_wr_select #(
    parameter int unsigned ADDR_W = vbu_pkg::ADDR_W,
    parameter int unsigned BASE_W = vbu_pkg::BASE_W,
    parameter int unsigned CODE_W = vbu_pkg::CODE_W,
    parameter logic [CODE_W-1:0] SEL_CODE = vbu_pkg::VBASE_CODE
) (
    input  logic              cpu_wr_en,
    input  logic [CODE_W-1:0] cpu_wr_code,
    input  logic [ADDR_W-1:0] cpu_wr_data,
    input  logic              dbg_wr_en,
    input  logic [CODE_W-1:0] dbg_wr_code,
    input  logic [ADDR_W-1:0] dbg_wr_data,
    output logic              wr_en,
    output logic [BASE_W-1:0] wr_hi
);
    localparam int unsigned LOW_W = ADDR_W - BASE_W;

    logic cpu_hit;
    logic dbg_hit;
    logic unused_low_bits;

    // Decode each source against the register code.
    always_comb begin
        cpu_hit = cpu_wr_en && (cpu_wr_code == SEL_CODE);
        dbg_hit = dbg_wr_en && (dbg_wr_code == SEL_CODE);
    end

    // Select the winning source; debug first.
    always_comb begin
        wr_en = cpu_hit || dbg_hit;
        if (dbg_hit) wr_hi = dbg_wr_data[ADDR_W-1:LOW_W];
        else         wr_hi = cpu_wr_data[ADDR_W-1:LOW_W];
    end

    assign unused_low_bits = ^{cpu_wr_data[LOW_W-1:0], dbg_wr_data[LOW_W-1:0]};

    // R5
    always_comb begin
        if (dbg_hit) debug_priority_chk: assert (wr_hi == dbg_wr_data[ADDR_W-1:LOW_W]);
    end
endmodule

// File: rtl/vbu_base_reg.sv
// Module: holds the implemented upper bits of the vector base.
// The bits below BASE_W are not stored and read as zero elsewhere.
// Synchronous active-low reset clears the field.
module vbu_base_reg #(
    parameter int unsigned BASE_W = vbu_pkg::BASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BASE_W-1:0] wr_hi,
    output logic [BASE_W-1:0] base_hi
);
    // Load the base field on a selected write.
    always_ff @(posedge clk) begin
        if (!rst_n)     base_hi <= '0;
        else if (wr_en) base_hi <= wr_hi;
    end

    // R2
    base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> base_hi == $past(wr_hi));
    // R4
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(base_hi));
    // R1
    base_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> base_hi == '0);
endmodule

// File: rtl/vbu_addr_gen.sv
// Module: forms the vector entry address from the base and vector number.
// Assumes the widest displacement fits below the stored base field, so the
// addition never carries into the base bits.
module vbu_addr_gen #(
    parameter int unsigned ADDR_W      = vbu_pkg::ADDR_W,
    parameter int unsigned BASE_W      = vbu_pkg::BASE_W,
    parameter int unsigned VEC_W       = vbu_pkg::VEC_W,
    parameter int unsigned ENTRY_SHIFT = vbu_pkg::ENTRY_SHIFT
) (
    input  logic [BASE_W-1:0] base_hi,
    input  logic [VEC_W-1:0]  vec_num,
    output logic [ADDR_W-1:0] vec_addr
);
    localparam int unsigned LOW_W  = ADDR_W - BASE_W;
    localparam int unsigned DISP_W = VEC_W + ENTRY_SHIFT;

    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W-1:0] disp;

    generate
        if (DISP_W > LOW_W) begin : g_bad_cfg
            initial $error("displacement wider than unstored base bits");
        end
    endgenerate

    // Scale the vector number into a byte displacement and add it to the base.
    always_comb begin
        base_full = {base_hi, {LOW_W{1'b0}}};
        disp      = {{(ADDR_W-DISP_W){1'b0}}, vec_num, {ENTRY_SHIFT{1'b0}}};
        vec_addr  = base_full + disp;
    end

    // R6
    always_comb begin
        addr_base_field_chk: assert (vec_addr[ADDR_W-1:LOW_W] == base_hi);
    end
endmodule

// File: rtl/vbu_dbg_read.sv
// Module: debug-side readback of the vector base.
// Data is registered and valid for one cycle after an accepted request.
// Bits below the stored field are driven zero.
module vbu_dbg_read #(
    parameter int unsigned ADDR_W = vbu_pkg::ADDR_W,
    parameter int unsigned BASE_W = vbu_pkg::BASE_W,
    parameter int unsigned CODE_W = vbu_pkg::CODE_W,
    parameter logic [CODE_W-1:0] SEL_CODE = vbu_pkg::VBASE_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [CODE_W-1:0] rd_code,
    input  logic [BASE_W-1:0] base_hi,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_data
);
    localparam int unsigned LOW_W = ADDR_W - BASE_W;

    logic rd_hit;

    // Decode the read request.
    always_comb rd_hit = rd_en && (rd_code == SEL_CODE);

    // Capture the base on an accepted read; clear data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_hit;
            rd_data  <= rd_hit ? {base_hi, {LOW_W{1'b0}}} : '0;
        end
    end

    // R7
    rd_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> rd_valid && rd_data[ADDR_W-1:LOW_W] == $past(base_hi));
    // R8
    rd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> !rd_valid);
    // R7
    rd_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_data[LOW_W-1:0] == '0);
endmodule

// File: rtl/vec_base_unit.sv
// Module: top of the exception vector base address unit.
// It ties together the write selection, base storage, address generation and
// debug readback. Processor-side read attempts are accepted at the port and
// then ignored.
module vec_base_unit #(
    parameter int unsigned ADDR_W      = vbu_pkg::ADDR_W,
    parameter int unsigned BASE_W      = vbu_pkg::BASE_W,
    parameter int unsigned CODE_W      = vbu_pkg::CODE_W,
    parameter int unsigned VEC_W       = vbu_pkg::VEC_W,
    parameter int unsigned ENTRY_SHIFT = vbu_pkg::ENTRY_SHIFT,
    parameter logic [CODE_W-1:0] SEL_CODE = vbu_pkg::VBASE_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [CODE_W-1:0] cpu_wr_code,
    input  logic [ADDR_W-1:0] cpu_wr_data,
    input  logic              cpu_rd_en,
    input  logic [CODE_W-1:0] cpu_rd_code,
    input  logic              dbg_wr_en,
    input  logic [CODE_W-1:0] dbg_wr_code,
    input  logic [ADDR_W-1:0] dbg_wr_data,
    input  logic              dbg_rd_en,
    input  logic [CODE_W-1:0] dbg_rd_code,
    output logic              dbg_rd_valid,
    output logic [ADDR_W-1:0] dbg_rd_data,
    input  logic [VEC_W-1:0]  vec_num,
    output logic [ADDR_W-1:0] vec_addr
);
    logic              wr_en;
    logic [BASE_W-1:0] wr_hi;
    logic [BASE_W-1:0] base_hi;
    logic              unused_cpu_rd;

    assign unused_cpu_rd = cpu_rd_en ^ (^cpu_rd_code);

    vbu_wr_select #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .CODE_W(CODE_W),
                    .SEL_CODE(SEL_CODE)) u_wr_select (
        .cpu_wr_en(cpu_wr_en), .cpu_wr_code(cpu_wr_code), .cpu_wr_data(cpu_wr_data),
        .dbg_wr_en(dbg_wr_en), .dbg_wr_code(dbg_wr_code), .dbg_wr_data(dbg_wr_data),
        .wr_en(wr_en), .wr_hi(wr_hi));

    vbu_base_reg #(.BASE_W(BASE_W)) u_base_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .base_hi(base_hi));

    vbu_addr_gen #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .VEC_W(VEC_W),
                   .ENTRY_SHIFT(ENTRY_SHIFT)) u_addr_gen (
        .base_hi(base_hi), .vec_num(vec_num), .vec_addr(vec_addr));

    vbu_dbg_read #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .CODE_W(CODE_W),
                   .SEL_CODE(SEL_CODE)) u_dbg_read (
        .clk(clk), .rst_n(rst_n), .rd_en(dbg_rd_en), .rd_code(dbg_rd_code),
        .base_hi(base_hi), .rd_valid(dbg_rd_valid), .rd_data(dbg_rd_data));

    // R9
    cpu_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_en && !dbg_rd_en) |=> !dbg_rd_valid);
endmodule

// File: tb/vec_base_unit_bench.sv
module vec_base_unit_bench;
    localparam logic [11:0] CODE = 12'h801;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_wr_en, cpu_rd_en, dbg_wr_en, dbg_rd_en;
    logic [11:0] cpu_wr_code, cpu_rd_code, dbg_wr_code, dbg_rd_code;
    logic [31:0] cpu_wr_data, dbg_wr_data, dbg_rd_data, vec_addr;
    logic        dbg_rd_valid;
    logic [7:0]  vec_num;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [11:0] m_base;

    always #4 clk = ~clk;

    vec_base_unit u_vec_base_unit (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_code(cpu_wr_code), .cpu_wr_data(cpu_wr_data),
        .cpu_rd_en(cpu_rd_en), .cpu_rd_code(cpu_rd_code),
        .dbg_wr_en(dbg_wr_en), .dbg_wr_code(dbg_wr_code), .dbg_wr_data(dbg_wr_data),
        .dbg_rd_en(dbg_rd_en), .dbg_rd_code(dbg_rd_code),
        .dbg_rd_valid(dbg_rd_valid), .dbg_rd_data(dbg_rd_data),
        .vec_num(vec_num), .vec_addr(vec_addr));

    function automatic logic [31:0] exp_addr(input logic [11:0] b, input logic [7:0] v);
        return {b, 20'h0} | {22'h0, v, 2'b00};
    endfunction

    function automatic logic [11:0] next_base(input logic [11:0] b,
            input logic ce, input logic [11:0] cc, input logic [31:0] cd,
            input logic de, input logic [11:0] dc, input logic [31:0] dd);
        if (de && dc == CODE) return dd[31:20];
        if (ce && cc == CODE) return cd[31:20];
        return b;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        cpu_wr_en = 0; cpu_rd_en = 0; dbg_wr_en = 0; dbg_rd_en = 0;
        cpu_wr_code = 0; cpu_rd_code = 0; dbg_wr_code = 0; dbg_rd_code = 0;
        cpu_wr_data = 0; dbg_wr_data = 0; vec_num = 0;
    endtask

    // Called at a negedge with inputs already driven; runs one clock cycle.
    task automatic step(input string req);
        logic        pv;
        logic [31:0] pd;
        #1;
        check({req, "/R6 addr"}, vec_addr, exp_addr(m_base, vec_num));
        pv = dbg_rd_en && dbg_rd_code == CODE;
        pd = {m_base, 20'h0};
        m_base = next_base(m_base, cpu_wr_en, cpu_wr_code, cpu_wr_data,
                           dbg_wr_en, dbg_wr_code, dbg_wr_data);
        @(negedge clk);
        check({req, "/R7 R8 R9 valid"}, {31'h0, dbg_rd_valid}, {31'h0, pv});
        if (pv) check({req, "/R7 data"}, dbg_rd_data, pd);
    endtask

    task automatic dbg_read_check(input string req);
        idle(); dbg_rd_en = 1; dbg_rd_code = CODE; vec_num = 8'h3C;
        step(req);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        idle();
        rst_n = 0;
        m_base = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        vec_num = 8'h10;
        #1;
        check("R1 addr", vec_addr, 32'h0000_0040);
        check("R1 valid", {31'h0, dbg_rd_valid}, 32'h0);
        @(negedge clk);
        dbg_read_check("R1 read");
        // R2 processor write, low bits ignored, max vector
        idle(); cpu_wr_en = 1; cpu_wr_code = CODE; cpu_wr_data = 32'hFFF1_2345; step("R2");
        idle(); vec_num = 8'hFF; step("R2/R6 max");
        check("R6 max vector", vec_addr, 32'hFFF0_03FC);
        dbg_read_check("R2 read");
        // R3 debug write
        idle(); dbg_wr_en = 1; dbg_wr_code = CODE; dbg_wr_data = 32'hA5BF_FFFF; step("R3");
        dbg_read_check("R3 read");
        // R4 near-miss codes
        idle(); cpu_wr_en = 1; cpu_wr_code = 12'h800; cpu_wr_data = 32'h1230_0000; step("R4 cpu");
        idle(); dbg_wr_en = 1; dbg_wr_code = 12'h001; dbg_wr_data = 32'h4560_0000; step("R4 dbg");
        dbg_read_check("R4 read");
        // R5 simultaneous writes
        idle(); cpu_wr_en = 1; cpu_wr_code = CODE; cpu_wr_data = 32'h1110_0000;
        dbg_wr_en = 1; dbg_wr_code = CODE; dbg_wr_data = 32'h7770_0000; step("R5");
        dbg_read_check("R5 read");
        // R7 read in same cycle as write returns old value
        idle(); dbg_rd_en = 1; dbg_rd_code = CODE;
        cpu_wr_en = 1; cpu_wr_code = CODE; cpu_wr_data = 32'h2220_0000; step("R7 same-cycle");
        dbg_read_check("R7 after");
        // R8 wrong read code
        idle(); dbg_rd_en = 1; dbg_rd_code = 12'h802; step("R8");
        // R9 processor read attempt
        idle(); cpu_rd_en = 1; cpu_rd_code = CODE; step("R9");
        dbg_read_check("R9 read");
        // Random mix
        for (int i = 0; i < 600; i++) begin
            idle();
            cpu_wr_en   = ($urandom % 4) == 0;
            cpu_wr_code = ($urandom % 2) ? CODE : 12'($urandom);
            cpu_wr_data = $urandom;
            dbg_wr_en   = ($urandom % 5) == 0;
            dbg_wr_code = ($urandom % 2) ? CODE : 12'($urandom);
            dbg_wr_data = $urandom;
            cpu_rd_en   = ($urandom % 3) == 0;
            cpu_rd_code = ($urandom % 2) ? CODE : 12'($urandom);
            dbg_rd_en   = ($urandom % 3) == 0;
            dbg_rd_code = ($urandom % 4) ? CODE : 12'($urandom);
            vec_num     = 8'($urandom);
            step("random R2 R3 R4 R5");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule